// File: doc/BRIEF.md
# Serial Memory Slave with Rolling Write Buffer

This block is the bus-facing half of a small serial memory that sits on a two-wire bus (I2C). It samples the clock line and the data line with the system clock, finds start and stop conditions, and takes in a device-address byte. On a match it acknowledges. A write then takes a word-address byte and any number of data bytes. A read streams bytes out of a 256-byte array, most significant bit first. SDA is driven only through an open-drain enable: a high `sda_oe` pulls the line low.

Write data is collected in a rolling buffer of `BUF_DEPTH` entries. When more bytes arrive than the buffer holds, the oldest are pushed out. A stop condition that closes a write starts a programming cycle of `PROG_CYCLES` system clocks, during which the buffered bytes are copied into the array. While that cycle runs, the slave answers nothing on the bus, so a master can poll its address until it acknowledges again.

Top module: `i2cw_slave`

## Requirements
- R1: After a start condition (SDA falls while SCL is high), the first byte is the 7-bit device address in bits 7..1 with the read flag in bit 0 (1 = read). If the address equals `DEV_ADDR` and no programming cycle is running, the slave holds SDA low for the whole high phase of the ninth SCL pulse.
- R2: An address byte that does not match gets no acknowledge. The slave then leaves SDA released for every later byte until the next start or stop.
- R3: In a write, the byte after the device address is the word address. It is acknowledged. It becomes the base for committing the write, and the pointer from which later reads start.
- R4: When a stop ends a write of 1 to 16 data bytes, the bytes land in the array at base, base+1, … in arrival order. No other location changes.
- R5: When a write carries more than 16 data bytes, only the last 16 are kept. They land at base..base+15, oldest kept byte first.
- R6: For `PROG_CYCLES` system clocks after a stop that ends a write with data, every byte, including a matching address, is left unacknowledged. Once that time has passed, a matching address is acknowledged again.
- R7: A read sends array bytes MSB first, starting at the pointer, and advances the pointer by one per byte. A master acknowledge (SDA low on the ninth pulse) asks for the next byte. A master non-acknowledge ends the read, and SDA stays released.
- R8: A start or stop in the middle of a byte aborts the transfer. A write ended by a start rather than a stop commits nothing and starts no programming cycle, and the start begins a new address phase.
- R9: The slave changes `sda_oe` only while SCL is low.
- R10: After reset, SDA is released, the bus state is idle and no programming cycle is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach is the buffer wrap that happens only inside one long write. It is followed by a commit window that is visible only indirectly, through the missing acknowledge. The bench sweeps write lengths below, at and above the buffer depth (1, 15, 16, 17, 20 and 33 bytes), each into its own region. After each write it reads back one byte past the kept range to confirm that nothing spilled over. The busy window is probed by addressing the slave right after the stop, and again after the cycle has expired. The abort case sends a full data byte, then three bits of a second one, then a repeated start, and reads the target location back.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADR, ST_WDAT, ST_ACK, ST_RD, ST_RACK, ST_WAIT
  } slv_st_t;
endpackage

// File: rtl/i2cw_bus_sync.sv
module i2cw_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_p} <= 3'b111;
      {sda_m, sda_s, sda_p} <= 3'b111;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_p <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  // R8: a start or stop is only recognised while the clock line is held high
  assert_event_needs_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> ($past(scl_s) && scl_s));
endmodule

// File: rtl/i2cw_wbuf.sv
module i2cw_wbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic [$clog2(DEPTH+1)-1:0]   rd_idx,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [IW-1:0] wp;
  logic [IW-1:0] ridx;
  int            tmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      count <= '0;
    end else if (push) begin
      wp    <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
      count <= (int'(count) == DEPTH) ? count : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) store[wp] <= din;
  end

  // oldest retained entry sits count places behind the write pointer
  always_comb begin
    tmp  = (int'(wp) + DEPTH - int'(count) + int'(rd_idx)) % DEPTH;
    ridx = IW'(tmp);
  end
  assign rd_data = store[ridx];

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  assert_full_stays_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && int'(count) == DEPTH) |=> (int'(count) == DEPTH));
  assert_no_push_on_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && clr));

  logic unused_cw;
  assign unused_cw = ^CW;
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         BUF_DEPTH   = 16,
  parameter int         PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2cw_pkg::*;

  localparam int CW        = $clog2(BUF_DEPTH+1);
  localparam int TW        = $clog2(PROG_CYCLES+1);
  localparam int MEM_DEPTH = 1 << WORD_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2cw_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  slv_st_t            st, ack_next;
  logic [3:0]         bitc;
  logic [BYTE_W-1:0]  sh;
  logic [WORD_W-1:0]  ptr, base;
  logic               wr_act, oe, busy;
  logic [BYTE_W-1:0]  mem [MEM_DEPTH];
  logic [BYTE_W-1:0]  rd_byte, buf_rd;
  logic [CW-1:0]      buf_cnt, ci, ccnt;
  logic [TW-1:0]      cyc;
  logic [WORD_W-1:0]  cbase, caddr;
  logic               byte_done, quiet_fall, buf_push, buf_clr;

  assign byte_done  = (bitc == 4'd8);
  assign quiet_fall = scl_fall && !start_ev && !stop_ev;
  assign buf_push   = quiet_fall && st == ST_WDAT && byte_done;
  assign buf_clr    = quiet_fall && st == ST_WADR && byte_done;
  assign rd_byte    = mem[ptr];
  assign caddr      = cbase + WORD_W'(ci);

  i2cw_wbuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push), .din(sh),
    .rd_idx(ci), .rd_data(buf_rd), .count(buf_cnt)
  );

  // bus protocol engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ack_next <= ST_IDLE; bitc <= '0; sh <= '0;
      ptr <= '0; base <= '0; wr_act <= 1'b0; oe <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV; bitc <= '0; oe <= 1'b0; wr_act <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; bitc <= '0; oe <= 1'b0; wr_act <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        ST_DEV, ST_WADR, ST_WDAT:
          if (!byte_done) begin
            sh   <= {sh[BYTE_W-2:0], sda_s};
            bitc <= bitc + 1'b1;
          end
        ST_RACK: if (sda_s) st <= ST_WAIT;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ST_DEV:
          if (byte_done) begin
            bitc <= '0;
            if (sh[7:1] == DEV_ADDR && !busy) begin
              oe <= 1'b1; st <= ST_ACK;
              ack_next <= sh[0] ? ST_RD : ST_WADR;
            end else begin
              st <= ST_WAIT;
            end
          end
        ST_WADR:
          if (byte_done) begin
            bitc <= '0; ptr <= sh; base <= sh; wr_act <= 1'b1;
            oe <= 1'b1; st <= ST_ACK; ack_next <= ST_WDAT;
          end
        ST_WDAT:
          if (byte_done) begin
            bitc <= '0; oe <= 1'b1; st <= ST_ACK; ack_next <= ST_WDAT;
          end
        ST_ACK: begin
          oe <= 1'b0;
          st <= ack_next;
          if (ack_next == ST_RD) begin
            sh <= rd_byte; oe <= ~rd_byte[7]; bitc <= 4'd1; ptr <= ptr + 1'b1;
          end
        end
        ST_RD:
          if (byte_done) begin
            oe <= 1'b0; st <= ST_RACK;
          end else begin
            oe <= ~sh[6]; sh <= {sh[BYTE_W-2:0], 1'b0}; bitc <= bitc + 1'b1;
          end
        ST_RACK: begin
          st <= ST_RD;
          sh <= rd_byte; oe <= ~rd_byte[7]; bitc <= 4'd1; ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe;

  // programming cycle: copy retained bytes, then stay busy until the timer ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cyc <= '0; ci <= '0; ccnt <= '0; cbase <= '0;
    end else if (stop_ev && wr_act && buf_cnt != '0 && !busy) begin
      busy <= 1'b1; cyc <= '0; ci <= '0; ccnt <= buf_cnt; cbase <= base;
    end else if (busy) begin
      cyc <= cyc + 1'b1;
      if (cyc == TW'(PROG_CYCLES-1)) busy <= 1'b0;
      if (ci < ccnt) ci <= ci + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (busy && ci < ccnt) begin
      mem[caddr] <= buf_rd;
    end
  end

  assert_ack_held_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK && scl_s) |-> sda_oe);
  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != ST_ACK));
  assert_commit_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  assert_oe_steady_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));
endmodule

// File: tb/i2cw_slave_bench.sv
module i2cw_slave_bench;
  localparam int H    = 8;
  localparam int PROG = 600;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   n_chk = 0;
  int   n_bad = 0;
  int   r9_viol = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  logic [7:0] rbuf [0:40];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2cw_slave #(.DEV_ADDR(DEV), .BUF_DEPTH(16), .PROG_CYCLES(PROG)) u_i2cw_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  // R9 monitor: slave output must not move while the clock line stays high
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && sda_oe != prev_oe) r9_viol++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dval(input int n, input int k);
    return 8'((n * 7 + k * 13 + 5) & 255);
  endfunction

  task automatic hp(input int c); repeat (c) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(H); scl = 1'b1; hp(H); sda_m = 1'b0; hp(H); scl = 1'b0; hp(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(H); scl = 1'b1; hp(H); sda_m = 1'b1; hp(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; hp(H); scl = 1'b1; hp(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hp(H); scl = 1'b1; hp(H/2);
    ack = (sda_bus == 1'b0);
    hp(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(H); scl = 1'b1; hp(H/2); b[i] = sda_bus; hp(H/2); scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp(H); scl = 1'b1; hp(H); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic write_tx(input logic [7:0] base, input int n);
    bit ack; int nacks = 0;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R1 address ack", ack, 1);
    send_byte(base, ack);        check(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(dval(n, k), ack);
      if (!ack) nacks++;
    end
    check(nacks == 0, "R4 data bytes acked", nacks, 0);
    bus_stop();
  endtask

  task automatic read_tx(input logic [7:0] base, input int n);
    bit ack; logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R1 address ack", ack, 1);
    send_byte(base, ack);        check(ack, "R3 word address ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check(ack, "R7 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      rbuf[k] = b;
    end
    hp(2);
    check(sda_oe == 1'b0, "R7 released after master nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ack; logic [7:0] b;
    int lens [6] = '{1, 15, 16, 17, 20, 33};
    hp(5);
    check(sda_oe == 1'b0, "R10 released in reset", sda_oe, 0);
    rst_n = 1'b1; hp(5);
    check(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);

    // short write, busy probe, recovery, read-back
    write_tx(8'h10, 4);
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check(!ack, "R6 address refused while programming", ack, 0);
    bus_stop();
    hp(PROG + 100);
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check(ack, "R6 address acked after programming", ack, 1);
    bus_stop();
    read_tx(8'h10, 5);
    for (int k = 0; k < 4; k++)
      check(rbuf[k] == dval(4, k), "R4 R7 sequential read-back", rbuf[k], dval(4, k));
    check(rbuf[4] == 8'h00, "R4 neighbour untouched", rbuf[4], 0);

    // length sweep around the buffer depth
    foreach (lens[j]) begin
      int n = lens[j];
      int kept = (n > 16) ? 16 : n;
      logic [7:0] base = 8'(8'h80 + 16 * j);
      write_tx(base, n);
      hp(PROG + 100);
      read_tx(base, kept + 1);
      for (int i = 0; i < kept; i++)
        check(rbuf[i] == dval(n, n - kept + i),
              (n > 16) ? "R5 newest sixteen kept" : "R4 all bytes kept",
              rbuf[i], dval(n, n - kept + i));
      check(rbuf[kept] == 8'h00, "R4 R5 nothing past kept range", rbuf[kept], 0);
    end

    // foreign address
    bus_start(); send_byte({7'h23, 1'b0}, ack);
    check(!ack, "R2 foreign address refused", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 silent until next start", ack, 0);
    bus_stop();

    // aborted write: full byte, partial byte, repeated start
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h30, ack);
    send_byte(8'h55, ack); check(ack, "R8 first data byte acked", ack, 1);
    send_bits(8'hA0, 3);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check(ack, "R8 new address phase after restart", ack, 1);
    recv_byte(1'b0, b);
    check(b == 8'h00, "R8 aborted write not committed", b, 0);
    bus_stop();
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check(ack, "R8 no programming cycle after abort", ack, 1);
    bus_stop();

    check(r9_viol == 0, "R9 output steady while clock high", r9_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule